// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block runs the memory side of a multi-word register transfer for a 32-bit core. After a one-cycle start pulse it takes a 16-bit register mask, a base address, a direction, a load/store select, a base register index and a writeback flag. It then makes one word access per selected register. Each access goes out through a request/acknowledge memory port, and only one access is outstanding at a time.

In increment mode the mask is walked from the lowest index upward, with addresses rising from the base. In decrement mode the mask is walked from the highest index downward, with addresses falling from the base. A store reads each register through a combinational register-file read port. A load writes each word through the register-file write port. Index 15 is the program counter and is never written by a load. Loading it instead produces a branch request, or a fault if the loaded word is misaligned.

Encodings that break the list and writeback rules are rejected in the cycle after start, and no access is made. When writeback is requested, the last accessed address goes back into the base register before the completion pulse.

Top module: `lsm_sequencer`

## Requirements
- R1: With `decMode`=0, the accesses visit the set mask bits in increasing index order. The addresses are base, base+4, …, base+4*(n-1), where n is the number of set bits.
- R2: With `decMode`=1, the accesses visit the set mask bits in decreasing index order. The addresses are base, base-4, …, base-4*(n-1).
- R3: A store (`isLoad`=0) drives `memWe`=1 and presents `rfRdIdx` equal to the register being stored. `memWdata` equals `rfRdData`.
- R4: For a load (`isLoad`=1), `rfWrEn` is asserted in each acknowledge cycle with `rfWrIdx` set to the register and `rfWrData` set to `memRdata`. Index 15 is the exception and is never written this way. `memWe` is 0 throughout a load.
- R5: When `writeBack`=1, `rfWrEn` is asserted for one cycle after the final acknowledge, with `rfWrIdx`=`baseIdx` and `rfWrData` equal to the last accessed address. When `writeBack`=0, no such write happens.
- R6: A start is illegal in any of these cases: the mask is empty, `baseIdx`=15, bit 13 is set, a store has bit 15 set, a load has both bits 14 and 15 set, or `writeBack`=1 and the mask contains `baseIdx`. An illegal start gives a one-cycle `illegal` pulse in the following cycle, with no memory request and no register write.
- R7: `memReq` and its address, write enable and write data stay unchanged until `memAck`. A new request is made only after the previous one is acknowledged.
- R8: A load that includes index 15 pulses `branchReq` in the cycle after that word's acknowledge, with `branchTarget` equal to the word with bit 0 cleared. If bit 0 of the word is 0, the block pulses `pcFault` instead.
- R9: `done` pulses for one cycle after the last acknowledge and any writeback. `busy` is high from the cycle after an accepted start through the `done` cycle. A start received while `busy` is ignored.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `memReq`, `rfWrEn`, `done`, `illegal`, `branchReq` and `pcFault` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| regList | input | 16 | Register selection mask |
| baseAddr | input | 32 | Base address |
| decMode | input | 1 | 0 = increment, 1 = decrement |
| isLoad | input | 1 | 1 = load, 0 = store |
| baseIdx | input | 4 | Base register index |
| writeBack | input | 1 | Write final address to base register |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 32 | Memory read data, valid with memAck |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-encoding pulse |
| branchReq | output | 1 | Program-counter load branch pulse |
| branchTarget | output | 32 | Branch target, bit 0 cleared |
| pcFault | output | 1 | Misaligned program-counter load pulse |

## Verification
The assertions check a few properties on every cycle. A pending request must stay stable until it is acknowledged. Each acknowledged increment-mode access must be followed either by no request or by the next higher word address. An illegal pulse must never coincide with activity. Register writes must not overlap a store, and branch pulses must follow only a load acknowledge. The completion pulse must be single and must return the block to idle.

Three behaviours need the bench's reference model, which predicts the exact access and write sequence from the mask:

- the visiting order over the mask and the data carried by each access;
- the writeback value;
- which of the six illegal cases is caught.

Ignoring a start while busy can be seen only in a scenario that fires a conflicting start mid-transfer. That scenario then confirms the original sequence still completes unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WBACK  = 2'd2,
    ST_FINISH = 2'd3
  } lsm_state_e;

  typedef struct packed {
    logic capture;
    logic advance;
  } lsm_strobe_t;
endpackage

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int STEP = 4,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  lsm_strobe_t     strb,
  input  logic [NREG-1:0] regList,
  input  logic [AW-1:0]   baseAddr,
  input  logic            decMode,
  output logic [IDXW-1:0] curIdx,
  output logic            isLast,
  output logic [AW-1:0]   curAddr
);
  logic [NREG-1:0] pendMask;
  logic            decQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendMask <= '0;
      curAddr  <= '0;
      decQ     <= 1'b0;
    end else if (strb.capture) begin
      pendMask <= regList;
      curAddr  <= baseAddr;
      decQ     <= decMode;
    end else if (strb.advance) begin
      pendMask[curIdx] <= 1'b0;
      if (!isLast)
        curAddr <= decQ ? curAddr - AW'(STEP) : curAddr + AW'(STEP);
    end
  end

  // priority pick: lowest set bit when incrementing, highest when decrementing
  always_comb begin
    curIdx = '0;
    if (decQ) begin
      for (int i = 0; i < NREG; i++)
        if (pendMask[i]) curIdx = IDXW'(i);
    end else begin
      for (int i = NREG-1; i >= 0; i--)
        if (pendMask[i]) curIdx = IDXW'(i);
    end
  end

  assign isLast = ((pendMask & (pendMask - NREG'(1))) == '0);
endmodule

// File: rtl/lsm_control.sv
module lsm_control
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int PC_IDX = NREG - 1,
  localparam int LR_IDX = NREG - 2,
  localparam int SP_IDX = NREG - 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] regList,
  input  logic            isLoad,
  input  logic [IDXW-1:0] baseIdx,
  input  logic            writeBack,
  input  logic            memAck,
  input  logic [DW-1:0]   memRdata,
  input  logic [IDXW-1:0] curIdx,
  input  logic            isLast,
  input  logic [AW-1:0]   curAddr,
  output lsm_strobe_t     strb,
  output logic            memReq,
  output logic            memWe,
  output logic            rfWrEn,
  output logic [IDXW-1:0] rfWrIdx,
  output logic [DW-1:0]   rfWrData,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            branchReq,
  output logic [DW-1:0]   branchTarget,
  output logic            pcFault
);
  lsm_state_e      state;
  logic            loadQ;
  logic            wbQ;
  logic [IDXW-1:0] baseIdxQ;
  logic            badEnc;
  logic            ackNow;
  logic            pcHit;

  always_comb begin
    badEnc = (regList == '0)
           || (baseIdx == IDXW'(PC_IDX))
           || regList[SP_IDX]
           || (!isLoad && regList[PC_IDX])
           || (isLoad && regList[PC_IDX] && regList[LR_IDX])
           || (writeBack && regList[baseIdx]);
  end

  assign ackNow       = (state == ST_ACCESS) && memAck;
  assign pcHit        = (curIdx == IDXW'(PC_IDX));
  assign strb.capture = (state == ST_IDLE) && start && !badEnc;
  assign strb.advance = ackNow;

  assign memReq   = (state == ST_ACCESS);
  assign memWe    = memReq && !loadQ;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);
  assign rfWrEn   = (ackNow && loadQ && !pcHit) || (state == ST_WBACK);
  assign rfWrIdx  = (state == ST_WBACK) ? baseIdxQ : curIdx;
  assign rfWrData = (state == ST_WBACK) ? DW'(curAddr) : memRdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      loadQ        <= 1'b0;
      wbQ          <= 1'b0;
      baseIdxQ     <= '0;
      illegal      <= 1'b0;
      branchReq    <= 1'b0;
      pcFault      <= 1'b0;
      branchTarget <= '0;
    end else begin
      illegal   <= 1'b0;
      branchReq <= 1'b0;
      pcFault   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (badEnc) begin
              illegal <= 1'b1;
            end else begin
              state    <= ST_ACCESS;
              loadQ    <= isLoad;
              wbQ      <= writeBack;
              baseIdxQ <= baseIdx;
            end
          end
        end
        ST_ACCESS: begin
          if (memAck) begin
            if (loadQ && pcHit) begin
              branchTarget <= {memRdata[DW-1:1], 1'b0};
              if (memRdata[0]) branchReq <= 1'b1;
              else             pcFault   <= 1'b1;
            end
            if (isLast) state <= wbQ ? ST_WBACK : ST_FINISH;
          end
        end
        ST_WBACK:  state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int STEP = 4,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] regList,
  input  logic [AW-1:0]   baseAddr,
  input  logic            decMode,
  input  logic            isLoad,
  input  logic [IDXW-1:0] baseIdx,
  input  logic            writeBack,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic            memAck,
  input  logic [DW-1:0]   memRdata,
  output logic [IDXW-1:0] rfRdIdx,
  input  logic [DW-1:0]   rfRdData,
  output logic            rfWrEn,
  output logic [IDXW-1:0] rfWrIdx,
  output logic [DW-1:0]   rfWrData,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            branchReq,
  output logic [DW-1:0]   branchTarget,
  output logic            pcFault
);
  lsm_strobe_t     strb;
  logic [IDXW-1:0] curIdx;
  logic            isLast;
  logic [AW-1:0]   curAddr;

  lsm_datapath #(.NREG(NREG), .AW(AW), .STEP(STEP)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .regList(regList),
    .baseAddr(baseAddr), .decMode(decMode),
    .curIdx(curIdx), .isLast(isLast), .curAddr(curAddr)
  );

  lsm_control #(.NREG(NREG), .AW(AW), .DW(DW)) i_ctl (
    .clk(clk), .rst(rst), .start(start), .regList(regList),
    .isLoad(isLoad), .baseIdx(baseIdx), .writeBack(writeBack),
    .memAck(memAck), .memRdata(memRdata), .curIdx(curIdx),
    .isLast(isLast), .curAddr(curAddr), .strb(strb),
    .memReq(memReq), .memWe(memWe), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .busy(busy),
    .done(done), .illegal(illegal), .branchReq(branchReq),
    .branchTarget(branchTarget), .pcFault(pcFault)
  );

  assign memAddr  = curAddr;
  assign rfRdIdx  = curIdx;
  assign memWdata = rfRdData;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int AW = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          decMode,
  input logic          busy,
  input logic          memReq,
  input logic          memWe,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic          rfWrEn,
  input logic          done,
  input logic          illegal,
  input logic          branchReq,
  input logic          pcFault
);
  logic decQ;
  always_ff @(posedge clk) begin
    if (rst) decQ <= 1'b0;
    else if (start && !busy) decQ <= decMode;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R7
  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck && !decQ) |=> (!memReq || memAddr == $past(memAddr) + AW'(STEP))); // R1
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck && decQ) |=> (!memReq || memAddr == $past(memAddr) - AW'(STEP))); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!busy && !memReq && !rfWrEn)); // R6
  AST_STORE_NO_RFWR: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWe) |-> !rfWrEn); // R4
  AST_BRANCH_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (branchReq || pcFault) |-> $past(memReq && memAck && !memWe)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !memReq && !done && !illegal && !branchReq && !pcFault)); // R10
endmodule

bind lsm_sequencer lsm_checker #(.AW(AW), .STEP(STEP)) i_lsm_checker (
  .clk(clk), .rst(rst), .start(start), .decMode(decMode), .busy(busy),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr),
  .rfWrEn(rfWrEn), .done(done), .illegal(illegal),
  .branchReq(branchReq), .pcFault(pcFault)
);

// File: tb/test_lsm_sequencer.sv
module test_lsm_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic        decMode = 1'b0, isLoad = 1'b0, writeBack = 1'b0;
  logic [3:0]  baseIdx = '0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic [31:0] rfRdData, rfWrData, branchTarget;
  logic        rfWrEn, busy, done, illegal, branchReq, pcFault;

  int nChecks = 0, nFails = 0;
  logic [31:0] rf [16];
  logic [31:0] mem [logic [31:0]];

  typedef struct { logic [31:0] addr; logic we; logic [31:0] data; } acc_t;
  typedef struct { logic [3:0] idx; logic [31:0] data; } wr_t;
  acc_t expAcc[$];
  wr_t  expWr[$];
  bit sawDone, sawIll, sawBr, sawFault;
  logic [31:0] gotTarget;
  int waitCnt = 0;

  always #5 clk = ~clk;

  lsm_sequencer i_lsm_sequencer (.*);

  assign rfRdData = rf[rfRdIdx];

  function automatic logic [31:0] memVal(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A00_0001);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural memory with 0..2 wait cycles
  always @(negedge clk) begin
    memAck <= 1'b0;
    if (memReq && !rst) begin
      if (waitCnt == 0) begin
        memAck   <= 1'b1;
        memRdata <= memVal(memAddr);
        if (memWe) mem[memAddr] = memWdata;
        waitCnt  = int'($urandom % 3);
      end else waitCnt--;
    end
  end

  // per-cycle comparison against the reference queues
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (memReq) begin
        if (expAcc.size() == 0) chk(0, "R7", "unexpected request addr", memAddr, 0);
        else begin
          chk(memAddr == expAcc[0].addr, expAcc[0].we ? "R1/R2 store" : "R1/R2 load", "address", memAddr, expAcc[0].addr);
          chk(memWe == expAcc[0].we, "R3", "write enable", memWe, expAcc[0].we);
          if (expAcc[0].we) chk(memWdata == expAcc[0].data, "R3", "store data", memWdata, expAcc[0].data);
          if (memAck) void'(expAcc.pop_front());
        end
      end
      if (rfWrEn) begin
        if (expWr.size() == 0) chk(0, "R4", "unexpected rf write idx", rfWrIdx, 0);
        else begin
          chk(rfWrIdx == expWr[0].idx, "R4/R5", "rf write index", rfWrIdx, expWr[0].idx);
          chk(rfWrData == expWr[0].data, "R4/R5", "rf write data", rfWrData, expWr[0].data);
          rf[rfWrIdx] = rfWrData;
          void'(expWr.pop_front());
        end
      end
      if (branchReq) begin sawBr = 1; gotTarget = branchTarget; end
      if (pcFault) sawFault = 1;
      if (done) sawDone = 1;
      if (illegal) sawIll = 1;
    end
  end

  task automatic runOp(logic [15:0] lst, logic [31:0] base, bit dec, bit ld,
                       logic [3:0] bidx, bit wb, bit expIll, bit poke, string tag);
    int n = 0;
    logic [31:0] a = base;
    bit expBr = 0, expFt = 0;
    logic [31:0] expTgt = '0;
    sawDone = 0; sawIll = 0; sawBr = 0; sawFault = 0;
    if (!expIll) begin
      for (int k = 0; k < 16; k++) begin
        int i = dec ? 15 - k : k;
        if (lst[i]) begin
          acc_t e;
          e.addr = a; e.we = !ld; e.data = ld ? memVal(a) : rf[i];
          expAcc.push_back(e);
          if (ld) begin
            if (i == 15) begin
              expTgt = {e.data[31:1], 1'b0};
              if (e.data[0]) expBr = 1; else expFt = 1;
            end else expWr.push_back('{idx: 4'(i), data: e.data});
          end
          a = dec ? a - 4 : a + 4;
          n++;
        end
      end
      if (wb) expWr.push_back('{idx: bidx, data: dec ? a + 4 : a - 4});
    end
    @(negedge clk);
    regList = lst; baseAddr = base; decMode = dec; isLoad = ld;
    baseIdx = bidx; writeBack = wb; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      regList = 16'h00F0; baseAddr = 32'hDEAD_0000; decMode = !dec; isLoad = !ld;
      writeBack = 0; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int t = 0; t < 200 && !sawDone && !sawIll; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    if (expIll) begin
      chk(sawIll, "R6", {tag, " illegal pulse"}, sawIll, 1);
      chk(!sawDone, "R6", {tag, " no done"}, sawDone, 0);
    end else begin
      chk(sawDone, "R9", {tag, " done seen"}, sawDone, 1);
      chk(!sawIll, "R6", {tag, " no illegal"}, sawIll, 0);
      chk(!busy, "R9", {tag, " idle after done"}, busy, 0);
    end
    chk(expAcc.size() == 0, "R1/R2", {tag, " all accesses made"}, expAcc.size(), 0);
    chk(expWr.size() == 0, "R4/R5", {tag, " all rf writes made"}, expWr.size(), 0);
    chk(sawBr == expBr, "R8", {tag, " branch pulse"}, sawBr, expBr);
    chk(sawFault == expFt, "R8", {tag, " fault pulse"}, sawFault, expFt);
    if (expBr) chk(gotTarget == expTgt, "R8", {tag, " branch target"}, gotTarget, expTgt);
    expAcc.delete(); expWr.delete();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1100_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !rfWrEn && !done && !illegal && !branchReq && !pcFault,
        "R10", "reset outputs quiet", {busy, memReq, rfWrEn, done, illegal, branchReq, pcFault}, 0);
    rst = 0;
    runOp(16'h0205, 32'h0000_1000, 0, 0, 4'd8, 0, 0, 0, "R1 R3 inc store");
    runOp(16'h1878, 32'h0000_2000, 1, 0, 4'd1, 1, 0, 0, "R2 R5 dec store wb");
    runOp(16'h0205, 32'h0000_1000, 0, 1, 4'd8, 1, 0, 0, "R4 R5 inc load wb");
    runOp(16'h1878, 32'h0000_2000, 1, 1, 4'd0, 0, 0, 0, "R2 R4 dec load");
    runOp(16'h0001, 32'h0000_3000, 1, 1, 4'd2, 1, 0, 0, "R5 single");
    runOp(16'h1FFF, 32'h0000_4000, 0, 1, 4'd14, 1, 0, 0, "R1 R4 full");
    mem[32'h0000_5004] = 32'h0000_8123;
    runOp(16'h8001, 32'h0000_5000, 0, 1, 4'd3, 0, 0, 0, "R8 pc load");
    mem[32'h0000_6000] = 32'h0000_9000;
    runOp(16'h8004, 32'h0000_6000, 1, 1, 4'd3, 1, 0, 0, "R8 pc fault");
    runOp(16'h0000, 32'h0000_7000, 0, 1, 4'd1, 0, 1, 0, "R6 empty");
    runOp(16'h0003, 32'h0000_7000, 0, 1, 4'd15, 0, 1, 0, "R6 pc base");
    runOp(16'h2001, 32'h0000_7000, 0, 0, 4'd1, 0, 1, 0, "R6 sp in list");
    runOp(16'h8001, 32'h0000_7000, 0, 0, 4'd1, 0, 1, 0, "R6 store pc");
    runOp(16'hC000, 32'h0000_7000, 0, 1, 4'd1, 0, 1, 0, "R6 pc and lr");
    runOp(16'h0022, 32'h0000_7000, 0, 1, 4'd5, 1, 1, 0, "R6 base in wb list");
    runOp(16'h0022, 32'h0000_7000, 0, 1, 4'd5, 0, 0, 0, "R6 base no wb ok");
    runOp(16'h0FFF, 32'h0000_8000, 0, 0, 4'd13, 0, 0, 1, "R9 start while busy");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL R9 watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule